// File: doc/BRIEF.md
# Multi-Cycle 32-bit Load/Store Processor Core

This block is a small non-pipelined 32-bit processor. It runs a subset of the classic register-register load/store instruction set. Each instruction passes through five register-transfer phases, one clock each: fetch, decode with register read, execute or address calculation, memory access or branch completion, and write-back. Between phases the core holds its state in internal registers: the instruction, the incremented PC, the two source operands, the sign-extended immediate, the execute result and the loaded data.

Instruction memory is read combinationally at the PC. Data memory is a single synchronous port with a one-cycle read latency. For a load, the core presents the address at the end of the execute phase, so the read data is ready in the memory phase. A debug port shows the PC and any register-file entry. An unsupported instruction stops the core until the next reset.

Top module: `mc_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core returns to PC 0, fetch phase, cleared registers and `halted` low.
- R2: Every instruction takes exactly five clocks. The PC changes only at the end of the memory phase, which is the fourth edge after a fetch starts.
- R3: Register 0 always reads 0. A write that targets it has no effect.
- R4: With opcode 0 (bits 31:26), funct (bits 5:0) selects the operation: 0x20 add, 0x22 sub, 0x24 and, 0x25 or. The operation uses rs (bits 25:21) and rt (bits 20:16) and writes rd (bits 15:11).
- R5: Opcode 0x08 writes rs plus the sign-extended 16-bit immediate (bits 15:0) into rt. Opcode 0x0F writes the immediate into the upper half of rt and clears the lower half.
- R6: Opcode 0x23 loads the word at rs plus the sign-extended immediate into rt. `dmem_re` is high only in the execute phase of a load.
- R7: Opcode 0x2B stores rt to rs plus the sign-extended immediate. `dmem_we` is high for one clock, in the memory phase only, and no register is written.
- R8: Opcode 0x04 branches when rs equals rt, and opcode 0x05 branches when they differ. The target is PC+4 plus the sign-extended immediate shifted left by 2. A branch not taken goes to PC+4.
- R9: Opcode 0x02 jumps to {PC+4[31:28], bits 25:0, 2'b00}.
- R10: Any other opcode, or opcode 0 with another funct, raises a sticky `halted` in the decode phase. The PC then freezes on that instruction, and no later memory writes or register writes take place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Instruction fetch address (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data write strobe |
| dmem_re | output | 1 | Data read strobe, data is returned one clock later |
| dmem_rdata | input | 32 | Registered read data |
| dbg_reg_sel | input | 5 | Register index for the debug view |
| dbg_reg_data | output | 32 | Contents of the selected register |
| dbg_pc | output | 32 | Current PC |
| halted | output | 1 | Sticky stop after an unsupported instruction |

## Verification
Each directed program runs until an unsupported word halts the core. The bench then compares registers and memory with values worked out by hand. The arithmetic program mixes a positive and a negative immediate, so that sign extension, operand order in sub and bitwise results all show up. The memory program uses a positive and a negative offset against one base, which separates correct address arithmetic from simple truncation. The branch programs contain taken and not-taken cases of both conditions, a backward loop and a jump, and each wrong path writes a register that must stay zero. A cycle-exact PC trace checks the five-phase timing, and a bad funct followed by a valid instruction shows that the halt is sticky.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LUI   = 6'h0F;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_BNE   = 6'h05;
    localparam logic [5:0] OP_J     = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    typedef enum logic [2:0] {
        PH_IF, PH_ID, PH_EX, PH_MEM, PH_WB, PH_HALT
    } phase_e;

    typedef enum logic [2:0] {
        CL_RR, CL_RI, CL_LUI, CL_LD, CL_ST, CL_BR, CL_JMP, CL_BAD
    } iclass_e;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR
    } alu_op_e;

    typedef struct packed {
        phase_e          ph;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] npc;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
        logic [XLEN-1:0] imm;
        logic [XLEN-1:0] res;
        logic [XLEN-1:0] lmd;
        logic            cond;
        logic            halt;
    } core_st_t;
endpackage

// File: rtl/mc_decode.sv
module mc_decode
    import mc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output iclass_e    cls,
    output alu_op_e    aop,
    output logic       br_ne
);
    always_comb begin
        cls   = CL_BAD;
        aop   = ALU_ADD;
        br_ne = 1'b0;
        case (opcode)
            OP_RTYPE: begin
                cls = CL_RR;
                case (funct)
                    FN_ADD:  aop = ALU_ADD;
                    FN_SUB:  aop = ALU_SUB;
                    FN_AND:  aop = ALU_AND;
                    FN_OR:   aop = ALU_OR;
                    default: cls = CL_BAD;
                endcase
            end
            OP_ADDI: cls = CL_RI;
            OP_LUI:  cls = CL_LUI;
            OP_LW:   cls = CL_LD;
            OP_SW:   cls = CL_ST;
            OP_BEQ:  cls = CL_BR;
            OP_BNE: begin
                cls   = CL_BR;
                br_ne = 1'b1;
            end
            OP_J:    cls = CL_JMP;
            default: cls = CL_BAD;
        endcase
    end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] z
);
    always_comb begin
        case (op)
            ALU_ADD: z = x + y;
            ALU_SUB: z = x - y;
            ALU_AND: z = x & y;
            default: z = x | y;
        endcase
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs_q [NREG];
    logic [W-1:0] regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            regs_q[i] <= rst ? '0 : regs_d[i];
        end
    end

    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];
    assign rd3 = regs_q[ra3];
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [W-1:0]  imem_addr,
    input  logic [W-1:0]  imem_rdata,
    output logic [W-1:0]  dmem_addr,
    output logic [W-1:0]  dmem_wdata,
    output logic          dmem_we,
    output logic          dmem_re,
    input  logic [W-1:0]  dmem_rdata,
    input  logic [AW-1:0] dbg_reg_sel,
    output logic [W-1:0]  dbg_reg_data,
    output logic [W-1:0]  dbg_pc,
    output logic          halted
);
    localparam logic [W-1:0] STEP = W'(4);

    core_st_t st_q, st_d;

    iclass_e cls;
    alu_op_e aop;
    logic    br_ne;

    logic [W-1:0] rs_val, rt_val;
    logic [W-1:0] alu_x, alu_y, alu_z;
    logic [W-1:0] ex_res;
    logic         ex_cond;

    logic          wb_we;
    logic [AW-1:0] wb_addr;
    logic [W-1:0]  wb_data;

    mc_decode u_dec (
        .opcode (st_q.ir[31:26]),
        .funct  (st_q.ir[5:0]),
        .cls    (cls),
        .aop    (aop),
        .br_ne  (br_ne)
    );

    mc_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (st_q.ir[21+AW-1:21]),
        .ra2 (st_q.ir[16+AW-1:16]),
        .ra3 (dbg_reg_sel),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .rd3 (dbg_reg_data),
        .we  (wb_we),
        .wa  (wb_addr),
        .wd  (wb_data)
    );

    // Operand steering for the execute phase
    always_comb begin
        alu_x = st_q.opa;
        alu_y = st_q.imm;
        case (cls)
            CL_RR:   alu_y = st_q.opb;
            CL_BR: begin
                alu_x = st_q.npc;
                alu_y = {st_q.imm[W-3:0], 2'b00};
            end
            default: ;
        endcase
    end

    mc_alu #(.W(W)) u_alu (
        .op (cls == CL_RR ? aop : ALU_ADD),
        .x  (alu_x),
        .y  (alu_y),
        .z  (alu_z)
    );

    always_comb begin
        ex_res  = alu_z;
        ex_cond = 1'b0;
        case (cls)
            CL_LUI: ex_res = {st_q.imm[15:0], 16'h0000};
            CL_BR:  ex_cond = (st_q.opa == st_q.opb) ^ br_ne;
            CL_JMP: begin
                ex_res  = {st_q.npc[W-1:W-4], st_q.ir[25:0], 2'b00};
                ex_cond = 1'b1;
            end
            default: ;
        endcase
    end

    // Next-state computation
    always_comb begin
        st_d       = st_q;
        wb_we      = 1'b0;
        wb_addr    = '0;
        wb_data    = st_q.res;
        dmem_we    = 1'b0;
        dmem_re    = 1'b0;
        dmem_addr  = st_q.res;
        dmem_wdata = st_q.opb;
        case (st_q.ph)
            PH_IF: begin
                st_d.ir  = imem_rdata;
                st_d.npc = st_q.pc + STEP;
                st_d.ph  = PH_ID;
            end
            PH_ID: begin
                st_d.opa = rs_val;
                st_d.opb = rt_val;
                st_d.imm = {{(W-16){st_q.ir[15]}}, st_q.ir[15:0]};
                if (cls == CL_BAD) begin
                    st_d.halt = 1'b1;
                    st_d.ph   = PH_HALT;
                end else begin
                    st_d.ph = PH_EX;
                end
            end
            PH_EX: begin
                st_d.res  = ex_res;
                st_d.cond = ex_cond;
                if (cls == CL_LD) begin
                    dmem_re   = 1'b1;
                    dmem_addr = ex_res;
                end
                st_d.ph = PH_MEM;
            end
            PH_MEM: begin
                if (cls == CL_LD) st_d.lmd = dmem_rdata;
                if (cls == CL_ST) dmem_we = 1'b1;
                if (((cls == CL_BR) || (cls == CL_JMP)) && st_q.cond) begin
                    st_d.pc = st_q.res;
                end else begin
                    st_d.pc = st_q.npc;
                end
                st_d.ph = PH_WB;
            end
            PH_WB: begin
                case (cls)
                    CL_RR: begin
                        wb_we   = 1'b1;
                        wb_addr = st_q.ir[11+AW-1:11];
                    end
                    CL_RI, CL_LUI: begin
                        wb_we   = 1'b1;
                        wb_addr = st_q.ir[16+AW-1:16];
                    end
                    CL_LD: begin
                        wb_we   = 1'b1;
                        wb_addr = st_q.ir[16+AW-1:16];
                        wb_data = st_q.lmd;
                    end
                    default: ;
                endcase
                st_d.ph = PH_IF;
            end
            default: st_d.ph = PH_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ph: PH_IF, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_addr = st_q.pc;
    assign dbg_pc    = st_q.pc;
    assign halted    = st_q.halt;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
    import mc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input phase_e      phase,
    input logic [31:0] pc,
    input logic        halted,
    input logic        dmem_we,
    input logic        dmem_re,
    input logic [4:0]  dbg_reg_sel,
    input logic [31:0] dbg_reg_data
);
    assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IF) |=> (phase == PH_ID));

    assert_pc_moves_in_mem_R2: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_MEM) |=> $stable(pc));

    assert_zero_reg_R3: assert property (@(posedge clk) disable iff (rst)
        (dbg_reg_sel == 5'd0) |-> (dbg_reg_data == 32'd0));

    assert_read_in_ex_R6: assert property (@(posedge clk) disable iff (rst)
        dmem_re |-> (phase == PH_EX));

    assert_write_in_mem_R7: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (phase == PH_MEM && !dmem_re));

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!dmem_we && phase == PH_HALT));
endmodule

bind mc_core mc_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .phase        (st_q.ph),
    .pc           (dbg_pc),
    .halted       (halted),
    .dmem_we      (dmem_we),
    .dmem_re      (dmem_re),
    .dbg_reg_sel  (dbg_reg_sel),
    .dbg_reg_data (dbg_reg_data)
);

// File: tb/sim_mc_core.sv
`timescale 1ns/100ps
module sim_mc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re;
    logic [4:0]  dbg_reg_sel = 5'd0;
    logic [31:0] dbg_reg_data, dbg_pc;
    logic        halted;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    localparam logic [31:0] HALT_W = 32'hFC00_0000;

    always #2.5 clk = ~clk;

    mc_core u0 (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata),
        .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
        .dbg_pc(dbg_pc), .halted(halted)
    );

    assign imem_rdata = imem[imem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
        dmem_rdata <= dmem[dmem_addr[7:2]];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired: actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'h00, fn[5:0]};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_j(int tgt);
        return {6'h02, tgt[25:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            imem[i] = HALT_W;
            dmem[i] = 32'h0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_halt(input string req);
        int n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(halted === 1'b1, req, {31'h0, halted}, 32'h1);
    endtask

    task automatic chk_reg(input int idx, input logic [31:0] exp, input string req);
        @(negedge clk);
        dbg_reg_sel = idx[4:0];
        #1;
        chk(dbg_reg_data === exp, req, dbg_reg_data, exp);
    endtask

    // R1 and R2: reset state and five-phase PC timing
    task automatic t_reset_timing();
        clear_mem();
        imem[0] = enc_i(8, 0, 1, 1);
        imem[1] = enc_i(8, 0, 2, 2);
        do_reset();
        chk(dbg_pc === 32'h0, "R1 pc after reset", dbg_pc, 32'h0);
        chk(halted === 1'b0, "R1 halted after reset", {31'h0, halted}, 32'h0);
        repeat (3) @(negedge clk);
        chk(dbg_pc === 32'h0, "R2 pc held before memory phase", dbg_pc, 32'h0);
        @(negedge clk);
        chk(dbg_pc === 32'h4, "R2 pc after four edges", dbg_pc, 32'h4);
        repeat (4) @(negedge clk);
        chk(dbg_pc === 32'h4, "R2 pc held in second instruction", dbg_pc, 32'h4);
        @(negedge clk);
        chk(dbg_pc === 32'h8, "R2 pc after nine edges", dbg_pc, 32'h8);
    endtask

    // R3, R4, R5: arithmetic, logic, immediates
    task automatic t_alu();
        clear_mem();
        imem[0] = enc_i(8, 0, 1, 5);
        imem[1] = enc_i(8, 0, 2, -3);
        imem[2] = enc_r(1, 2, 3, 'h20);
        imem[3] = enc_r(1, 2, 4, 'h22);
        imem[4] = enc_r(1, 2, 5, 'h24);
        imem[5] = enc_r(1, 2, 6, 'h25);
        imem[6] = enc_i('h0F, 0, 7, 'h1234);
        imem[7] = enc_i(8, 0, 0, 7);
        imem[8] = enc_r(1, 1, 0, 'h20);
        do_reset();
        run_to_halt("R10 alu program halts");
        chk_reg(1, 32'h5, "R5 addi positive");
        chk_reg(2, 32'hFFFF_FFFD, "R5 addi negative sign extension");
        chk_reg(3, 32'h2, "R4 add");
        chk_reg(4, 32'h8, "R4 sub");
        chk_reg(5, 32'h5, "R4 and");
        chk_reg(6, 32'hFFFF_FFFD, "R4 or");
        chk_reg(7, 32'h1234_0000, "R5 lui");
        chk_reg(0, 32'h0, "R3 register 0 ignores writes");
        chk(dbg_pc === 32'h24, "R10 pc frozen at halt word", dbg_pc, 32'h24);
    endtask

    // R6, R7: loads and stores with positive and negative offsets
    task automatic t_mem();
        clear_mem();
        dmem[3] = 32'hCAFE_F00D;
        imem[0] = enc_i(8, 0, 1, 16);
        imem[1] = enc_i(8, 0, 2, 'h55);
        imem[2] = enc_i('h2B, 1, 2, 4);
        imem[3] = enc_i('h23, 1, 3, 4);
        imem[4] = enc_i('h23, 1, 4, -4);
        imem[5] = enc_i('h2B, 1, 4, -16);
        do_reset();
        run_to_halt("R10 memory program halts");
        chk(dmem[5] === 32'h55, "R7 store word at base+4", dmem[5], 32'h55);
        chk(dmem[0] === 32'hCAFE_F00D, "R7 store with negative offset", dmem[0], 32'hCAFE_F00D);
        chk_reg(3, 32'h55, "R6 load after store");
        chk_reg(4, 32'hCAFE_F00D, "R6 load with negative offset");
        chk_reg(2, 32'h55, "R7 store leaves rt unchanged");
    endtask

    // R8, R9: branches both ways and a jump
    task automatic t_branch();
        clear_mem();
        imem[0]  = enc_i(8, 0, 1, 1);
        imem[1]  = enc_i(8, 0, 2, 1);
        imem[2]  = enc_i(4, 1, 2, 2);
        imem[3]  = enc_i(8, 0, 3, 9);
        imem[4]  = enc_i(8, 0, 3, 8);
        imem[5]  = enc_i(5, 1, 2, 5);
        imem[6]  = enc_i(8, 0, 4, 4);
        imem[7]  = enc_i(5, 1, 0, 1);
        imem[8]  = enc_i(8, 0, 5, 1);
        imem[9]  = enc_j(11);
        imem[10] = enc_i(8, 0, 6, 6);
        imem[11] = enc_i(4, 1, 0, 3);
        imem[12] = enc_i(8, 0, 7, 7);
        do_reset();
        run_to_halt("R10 branch program halts");
        chk_reg(3, 32'h0, "R8 beq taken skips");
        chk_reg(4, 32'h4, "R8 bne not taken falls through");
        chk_reg(5, 32'h0, "R8 bne taken skips");
        chk_reg(6, 32'h0, "R9 jump skips");
        chk_reg(7, 32'h7, "R8 beq not taken falls through");
        chk(dbg_pc === 32'h34, "R9 final pc", dbg_pc, 32'h34);
    endtask

    // R8: backward branch loop
    task automatic t_loop();
        clear_mem();
        imem[0] = enc_i(8, 0, 1, 3);
        imem[1] = enc_i(8, 2, 2, 2);
        imem[2] = enc_i(8, 1, 1, -1);
        imem[3] = enc_i(5, 1, 0, -3);
        do_reset();
        run_to_halt("R10 loop halts");
        chk_reg(2, 32'h6, "R8 backward loop count");
        chk_reg(1, 32'h0, "R8 loop counter");
        chk(dbg_pc === 32'h10, "R8 loop exit pc", dbg_pc, 32'h10);
    endtask

    // R10: bad funct halts and later instructions never run
    task automatic t_halt();
        clear_mem();
        imem[0] = enc_i(8, 0, 1, 1);
        imem[1] = enc_r(1, 1, 3, 'h3F);
        imem[2] = enc_i(8, 0, 2, 2);
        imem[3] = enc_i('h2B, 0, 1, 0);
        do_reset();
        run_to_halt("R10 bad funct halts");
        repeat (20) @(negedge clk);
        chk(halted === 1'b1, "R10 halt sticky", {31'h0, halted}, 32'h1);
        chk(dbg_pc === 32'h4, "R10 pc frozen", dbg_pc, 32'h4);
        chk_reg(2, 32'h0, "R10 no later register write");
        chk_reg(3, 32'h0, "R10 bad funct writes nothing");
        chk(dmem[0] === 32'h0, "R10 no later store", dmem[0], 32'h0);
        do_reset();
        chk(halted === 1'b0, "R1 reset clears halt", {31'h0, halted}, 32'h0);
        chk(dbg_pc === 32'h0, "R1 reset clears pc", dbg_pc, 32'h0);
    endtask

    initial begin
        t_reset_timing();
        t_alu();
        t_mem();
        t_branch();
        t_loop();
        t_halt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule